// File: doc/BRIEF.md
# Euclid GCD Unit

This block returns the greatest common divisor of two 8-bit unsigned operands. It uses the remainder form of Euclid's method. A rising edge on the start input captures both operand buses into two working registers. The control then orders the pair so that the larger value sits in the first register. After that it loops: it hands the pair to a remainder sub-unit, waits for that sub-unit's done pulse, and then moves the old divisor down while the remainder becomes the new divisor. The loop stops when a remainder of zero comes back. At that point the current divisor is the result.

When the two operands are equal, the loop is skipped and the result appears after a single compare cycle. The remainder sub-unit is a restoring shift-and-subtract divider that needs one cycle per operand bit. The control and the sub-unit talk through a one-cycle go strobe and a one-cycle done pulse. The result is published through a ready flag and an answer bus. Both are held until the next accepted start edge. A caller must never present a zero operand.

Top module: `gcd_unit`

## Requirements
- R1: A rising edge on `startIn` seen while the unit is idle or holding a result captures `opA` and `opB`, and `readyOut` is low from the clock edge that samples that rise.
- R2: When `opA` equals `opB`, `readyOut` rises on the second rising clock edge counted from the edge that samples the start rise, and `answer` equals the operand.
- R3: When the captured first operand is smaller than the second, the registers exchange contents in a single cycle before the loop. The result does not depend on operand order.
- R4: Each loop step replaces the pair (a, b) with (b, a mod b) until the remainder is zero. The final `answer` is the greatest common divisor.
- R5: Once `readyOut` is high, it stays high and `answer` stays unchanged until the next accepted start rise, whatever the operand buses do.
- R6: A start rise that arrives while a computation is in progress is ignored. The running computation finishes with its original operands.
- R7: Start is edge-sensitive. Holding `startIn` high through completion does not start a second computation and does not clear `readyOut`.
- R8: After reset, `readyOut` is low and `answer` is zero.
- R9: The remainder sub-unit produces a single-cycle done pulse. Its remainder is smaller than the divisor, and this holds over long chains of steps.
- R10: For operands 15 and 24, the remainders run 9, 6, 3, 0 and `answer` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request; its rising edge is the trigger |
| opA | input | 8 | First operand, nonzero |
| opB | input | 8 | Second operand, nonzero |
| readyOut | output | 1 | High while a result is held |
| answer | output | 8 | Greatest common divisor of the last accepted pair |

## Verification
Two things can meet in the same cycle: a fresh start rise, and the control being busy inside the remainder loop. The bench provokes this in two ways. First, it pulses start with a different operand pair a few cycles into a run. Second, it holds start high across a completion, so that the done state and a still-high start coexist. In both cases the bench judges only the result, by checking that the answer belongs to the first pair and that ready does not drop. A second case of cycle sharing is the equal-operand early exit. Here the compare cycle must decide to finish at once, and the bench checks that ready arrives on exactly the second edge after the sampled start rise.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_REMGO,
    ST_WAIT,
    ST_DONE
  } gcdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operand buses
    logic swap;     // exchange working registers
    logic remGo;    // launch remainder sub-unit
    logic step;     // (a,b) <= (b, a mod b)
    logic capture;  // publish divisor as answer
  } gcdCtrl_t;

endpackage

// File: rtl/gcd_rem.sv
module gcd_rem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] remOut
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quoQ, remQ, divQ;
  logic [CW-1:0] cntQ;
  logic          busyQ, doneQ;
  logic [W:0]    trial, diff;
  logic          fits;

  always_comb begin
    trial = {remQ, quoQ[W-1]};
    fits  = trial >= {1'b0, divQ};
    diff  = trial - {1'b0, divQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoQ  <= '0;
      remQ  <= '0;
      divQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (go) begin
      quoQ  <= dividend;
      divQ  <= divisor;
      remQ  <= '0;
      cntQ  <= CW'(W);
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (busyQ) begin
      remQ <= fits ? diff[W-1:0] : trial[W-1:0];
      quoQ <= {quoQ[W-2:0], 1'b0};
      cntQ <= cntQ - 1'b1;
      if (cntQ == CW'(1)) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign done   = doneQ;
  assign remOut = remQ;

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: remainder below divisor
  a_r9_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remOut < divQ));

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     isEqual,
  input  logic     isLess,
  input  logic     remDone,
  input  logic     remZero,
  output gcdCtrl_t ctrl,
  output logic     readyOut
);
  gcdState_t stateQ, stateD;
  logic      startPrev, startRise, busy, accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      stateQ    <= ST_IDLE;
    end else begin
      startPrev <= startIn;
      stateQ    <= stateD;
    end
  end

  assign startRise = startIn & ~startPrev;
  assign busy      = (stateQ == ST_CMP) || (stateQ == ST_REMGO) || (stateQ == ST_WAIT);
  assign accept    = startRise && !busy;

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          ctrl.load = 1'b1;
          stateD    = ST_CMP;
        end
      end
      ST_CMP: begin
        if (isEqual) begin
          ctrl.capture = 1'b1;
          stateD       = ST_DONE;
        end else begin
          ctrl.swap = isLess;
          stateD    = ST_REMGO;
        end
      end
      ST_REMGO: begin
        ctrl.remGo = 1'b1;
        stateD     = ST_WAIT;
      end
      ST_WAIT: begin
        if (remDone) begin
          if (remZero) begin
            ctrl.capture = 1'b1;
            stateD       = ST_DONE;
          end else begin
            ctrl.step = 1'b1;
            stateD    = ST_REMGO;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign readyOut = (stateQ == ST_DONE);

  // R2: equal pair finishes straight from compare
  a_r2_equal_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CMP && isEqual) |=> (stateQ == ST_DONE));
  // R5: result held until a start rise
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && !startRise) |=> readyOut);
  // R1: accepted start drops ready
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !readyOut);
  // R6: start while busy does not restart
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startRise) |=> (stateQ != ST_CMP));
  // R9: launch always followed by waiting
  a_r9_launch_wait: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.remGo |=> (stateQ == ST_WAIT));

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  gcdCtrl_t     ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         isEqual,
  output logic         isLess,
  output logic         remDone,
  output logic         remZero,
  output logic [W-1:0] answer
);
  logic [W-1:0] rg1Q, rg2Q, ansQ, remVal;

  gcd_rem #(.W(W)) u_rem (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctrl.remGo),
    .dividend (rg1Q),
    .divisor  (rg2Q),
    .done     (remDone),
    .remOut   (remVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rg1Q <= '0;
      rg2Q <= '0;
      ansQ <= '0;
    end else begin
      if (ctrl.load) begin
        rg1Q <= opA;
        rg2Q <= opB;
      end else if (ctrl.swap) begin
        rg1Q <= rg2Q;
        rg2Q <= rg1Q;
      end else if (ctrl.step) begin
        rg1Q <= rg2Q;
        rg2Q <= remVal;
      end
      if (ctrl.capture) ansQ <= rg2Q;
    end
  end

  assign isEqual = (rg1Q == rg2Q);
  assign isLess  = (rg1Q < rg2Q);
  assign remZero = (remVal == '0);
  assign answer  = ansQ;

  // R3: after exchange the larger value leads
  a_r3_swap_order: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.swap |=> (rg1Q > rg2Q));
  // R4: each step shrinks the divisor
  a_r4_step_shrink: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> (rg2Q < rg1Q));
  // R5: answer moves only on capture
  a_r5_answer_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(answer));

endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         readyOut,
  output logic [W-1:0] answer
);
  gcdCtrl_t ctrl;
  logic     isEqual, isLess, remDone, remZero;

  gcd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .isEqual  (isEqual),
    .isLess   (isLess),
    .remDone  (remDone),
    .remZero  (remZero),
    .ctrl     (ctrl),
    .readyOut (readyOut)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .isEqual (isEqual),
    .isLess  (isLess),
    .remDone (remDone),
    .remZero (remZero),
    .answer  (answer)
  );

endmodule

// File: tb/gcd_unit_tb.sv
module gcd_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic       readyOut;
  logic [7:0] answer;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gcd_unit u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .opA(opA), .opB(opB), .readyOut(readyOut), .answer(answer)
  );

  // {a, b, expected gcd}
  localparam logic [23:0] VEC [12] = '{
    {8'd15,  8'd24,  8'd3},
    {8'd24,  8'd15,  8'd3},
    {8'd7,   8'd7,   8'd7},
    {8'd1,   8'd255, 8'd1},
    {8'd255, 8'd1,   8'd1},
    {8'd144, 8'd89,  8'd1},
    {8'd128, 8'd64,  8'd64},
    {8'd200, 8'd150, 8'd50},
    {8'd255, 8'd255, 8'd255},
    {8'd17,  8'd34,  8'd17},
    {8'd252, 8'd198, 8'd18},
    {8'd91,  8'd65,  8'd13}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse start for one cycle; returns edges until ready
  task automatic runOp(input logic [7:0] a, input logic [7:0] b, output int lat);
    @(negedge clk);
    opA = a; opB = b; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(readyOut == 1'b0, "R1 ready low after start", readyOut, 0);
    lat = 1;
    while (!readyOut && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    check(lat < 3000, "R4 completion timeout", lat, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [7:0] held;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(readyOut == 1'b0, "R8 ready in reset", readyOut, 0);
    check(answer == 8'd0, "R8 answer in reset", answer, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(readyOut == 1'b0 && answer == 8'd0, "R8 after reset", answer, 0);

    // vector table: R3 order, R4 result, R9 long chains
    foreach (VEC[i]) begin
      runOp(VEC[i][23:16], VEC[i][15:8], lat);
      check(answer == VEC[i][7:0], "R4 gcd result", answer, VEC[i][7:0]);
      if (VEC[i][23:16] == VEC[i][15:8])
        check(lat == 2, "R2 equal early exit latency", lat, 2);
    end

    // R10: worked example
    runOp(8'd15, 8'd24, lat);
    check(answer == 8'd3, "R10 15/24 answer", answer, 3);
    check(lat > 2, "R3 unequal pair not early", lat, 3);

    // R9: many-step chain consistency
    runOp(8'd233, 8'd144, lat);
    check(answer == 8'd1, "R9 long remainder chain", answer, 1);

    // R5: hold while operands change
    held = answer;
    opA = 8'd99; opB = 8'd33;
    repeat (20) @(negedge clk);
    check(readyOut == 1'b1, "R5 ready held", readyOut, 1);
    check(answer == held, "R5 answer held", answer, held);

    // R6: second start while busy
    @(negedge clk);
    opA = 8'd15; opB = 8'd24; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    opA = 8'd7; opB = 8'd7; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    lat = 0;
    while (!readyOut && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    check(answer == 8'd3, "R6 busy start ignored", answer, 3);
    repeat (5) @(negedge clk);
    check(readyOut == 1'b1 && answer == 8'd3, "R6 no late restart", answer, 3);

    // R7: start held high through completion
    @(negedge clk);
    opA = 8'd10; opB = 8'd4; startIn = 1'b1;
    @(negedge clk);
    check(readyOut == 1'b0, "R1 held start clears ready", readyOut, 0);
    lat = 0;
    while (!readyOut && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    check(answer == 8'd2, "R7 held start result", answer, 2);
    opA = 8'd9; opB = 8'd9;
    repeat (10) @(negedge clk);
    check(readyOut == 1'b1, "R7 level does not retrigger", readyOut, 1);
    check(answer == 8'd2, "R7 answer unchanged", answer, 2);
    startIn = 1'b0;
    @(negedge clk);

    // R1: new start after hold captures fresh operands
    runOp(8'd12, 8'd18, lat);
    check(answer == 8'd6, "R1 fresh operands captured", answer, 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule